// File: doc/BRIEF.md
# Signed ALU with Condition Flags and Branch Test

This block is the execute-stage arithmetic unit of a small 32-bit register machine. Each cycle it takes a two-bit operation code and two register operands: A, the source, and B, which is both the source and the destination. It computes one of four operations and registers the result. It also keeps three condition flags in a register: signed overflow, zero and negative. There is no carry flag.

The flags are updated only when the flag-write enable is high. The enable is high for the four arithmetic and logic operations. Data-move instructions leave the enable low so that the flags keep their values.

A separate branch-condition input selects one of seven signed jump tests. The test is evaluated against the stored flags and drives a jump-taken output. The register file, memory, instruction fetch and program-counter update sit outside this block.

Top module: `alu_cc_unit`

## Requirements
- R1: With op code 0 (add), `result_q` equals B + A modulo 2^32 on the clock edge after the operands are applied.
- R2: With op code 1 (subtract), `result_q` equals B − A modulo 2^32 one edge later.
- R3: With op code 2, `result_q` is B AND A, and with op code 3 it is B XOR A, one edge later.
- R4: On a flag update, the overflow flag is set only for a signed overflow. For add this means A and B share a sign and the sum's sign differs from it. For subtract it means A and B differ in sign and the difference's sign differs from B's sign. For codes 2 and 3 the overflow flag is cleared.
- R5: On a flag update, the zero flag is set exactly when the new result is 0, and the negative flag equals bit 31 of the new result.
- R6: When `flag_we` is low, all three flags keep their values across the edge, while `result_q` is still updated.
- R7: While `rst` is high at a clock edge, `result_q` becomes 0 and the flags become zero=1, negative=0, overflow=0.
- R8: `jump_taken` follows the branch code. Code 0 is always taken. Code 1 is taken when (neg≠ovf) or zero. Code 2 is taken when neg≠ovf. Code 3 is taken when zero. Code 4 is taken when not zero. Code 5 is taken when neg=ovf. Code 6 is taken when (neg=ovf) and not zero.
- R9: Branch codes 7 to 15 give `jump_taken` = 0 whatever the flags are.
- R10: `jump_taken` depends only on the stored flags. A flag-updating operation in progress changes `jump_taken` only after the edge that stores its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 2 | 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_a | input | 32 | Source operand A |
| opnd_b | input | 32 | Source/destination operand B |
| flag_we | input | 1 | Store the flags of this operation |
| br_code | input | 4 | Jump condition select |
| result_q | output | 32 | Registered result |
| flag_ovf | output | 1 | Stored signed-overflow flag |
| flag_zero | output | 1 | Stored zero flag |
| flag_neg | output | 1 | Stored negative flag |
| jump_taken | output | 1 | Selected condition holds on stored flags |

## Verification
Some properties are checked by assertions on every cycle:
- the zero and negative flags agree with the stored result after an update;
- the flags hold when no update is requested;
- logic operations leave overflow cleared;
- branch code 0 is always taken and codes 7 to 15 are never taken.

Other behaviour only the bench scenarios can show. These are the exact arithmetic values, the overflow boundary cases at the most positive and most negative values, and the full jump truth table over different flag states. They also include the timing point that a pending flag update does not affect `jump_taken` before its edge.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    BR_ALWAYS = 4'd0,
    BR_LE     = 4'd1,
    BR_LT     = 4'd2,
    BR_EQ     = 4'd3,
    BR_NE     = 4'd4,
    BR_GE     = 4'd5,
    BR_GT     = 4'd6
  } br_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic neg;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{ovf: 1'b0, zero: 1'b1, neg: 1'b0};
endpackage

// File: rtl/alu_cc_compute.sv
module alu_cc_compute
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] res,
  output flags_t       flags_nxt
);
  localparam int MSB = W - 1;

  logic sa, sb, sr;

  always_comb begin
    unique case (op_e'(op_code))
      OP_ADD:  res = opnd_b + opnd_a;
      OP_SUB:  res = opnd_b - opnd_a;
      OP_AND:  res = opnd_b & opnd_a;
      default: res = opnd_b ^ opnd_a;
    endcase
  end

  assign sa = opnd_a[MSB];
  assign sb = opnd_b[MSB];
  assign sr = res[MSB];

  always_comb begin
    flags_nxt.zero = (res == '0);
    flags_nxt.neg  = sr;
    unique case (op_e'(op_code))
      OP_ADD:  flags_nxt.ovf = (sa == sb) && (sr != sa);
      OP_SUB:  flags_nxt.ovf = (sa != sb) && (sr != sb);
      default: flags_nxt.ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_state.sv
module alu_cc_state
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flag_we,
  input  logic [W-1:0] res_d,
  input  flags_t       flags_d,
  output logic [W-1:0] res_q,
  output flags_t       flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= FLAGS_RESET;
    end else begin
      res_q <= res_d;
      if (flag_we) flags_q <= flags_d;
    end
  end

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags_q));
endmodule

// File: rtl/alu_cc_branch.sv
module alu_cc_branch
  import alu_cc_pkg::*;
#(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] br_code,
  input  flags_t        flags_q,
  output logic          taken
);
  logic lt, eq;

  assign lt = flags_q.neg ^ flags_q.ovf;
  assign eq = flags_q.zero;

  always_comb begin
    case (br_code)
      BW'(BR_ALWAYS): taken = 1'b1;
      BW'(BR_LE):     taken = lt | eq;
      BW'(BR_LT):     taken = lt;
      BW'(BR_EQ):     taken = eq;
      BW'(BR_NE):     taken = !eq;
      BW'(BR_GE):     taken = !lt;
      BW'(BR_GT):     taken = !lt && !eq;
      default:        taken = 1'b0;
    endcase
  end

  a_r9_bad_code_not_taken: assert property (@(posedge clk) disable iff (rst)
    (br_code > BW'(6)) |-> !taken);
  a_r8_always_taken: assert property (@(posedge clk) disable iff (rst)
    (br_code == '0) |-> taken);
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int W  = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    op_code,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic          flag_we,
  input  logic [BW-1:0] br_code,
  output logic [W-1:0]  result_q,
  output logic          flag_ovf,
  output logic          flag_zero,
  output logic          flag_neg,
  output logic          jump_taken
);
  logic [W-1:0] res_d;
  flags_t       flags_d, flags_q;

  alu_cc_compute #(.W(W)) u_compute (
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res(res_d), .flags_nxt(flags_d)
  );

  alu_cc_state #(.W(W)) u_state (
    .clk(clk), .rst(rst), .flag_we(flag_we),
    .res_d(res_d), .flags_d(flags_d),
    .res_q(result_q), .flags_q(flags_q)
  );

  alu_cc_branch #(.BW(BW)) u_branch (
    .clk(clk), .rst(rst), .br_code(br_code),
    .flags_q(flags_q), .taken(jump_taken)
  );

  assign flag_ovf  = flags_q.ovf;
  assign flag_zero = flags_q.zero;
  assign flag_neg  = flags_q.neg;

  a_r5_zero_matches: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (flag_zero == (result_q == '0)));
  a_r5_neg_matches: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (flag_neg == result_q[W-1]));
  a_r4_logic_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_code[1]) |=> !flag_ovf);
endmodule

// File: tb/sim_alu_cc_unit.sv
module sim_alu_cc_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic        flag_we;
  logic [3:0]  br_code;
  logic [31:0] result_q;
  logic        flag_ovf, flag_zero, flag_neg, jump_taken;

  int checks = 0;
  int errors = 0;
  logic e_ovf = 1'b0, e_zero = 1'b1, e_neg = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  alu_cc_unit u0 (
    .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flag_we(flag_we), .br_code(br_code), .result_q(result_q),
    .flag_ovf(flag_ovf), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .jump_taken(jump_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_res(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      2'd0: return b + a;
      2'd1: return b - a;
      2'd2: return b & a;
      default: return b ^ a;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    if (op == 2'd0) r = sb + sa;
    else if (op == 2'd1) r = sb - sa;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic logic ref_jump(input int code, input logic o, input logic z, input logic n);
    case (code)
      0: return 1'b1;
      1: return (n != o) || z;
      2: return n != o;
      3: return z;
      4: return !z;
      5: return n == o;
      6: return (n == o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  // apply one operation, check result and flags after the edge
  task automatic do_op(input string req, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic we);
    logic [31:0] r;
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; flag_we = we;
    r = ref_res(op, a, b);
    if (we) begin
      e_ovf = ref_ovf(op, a, b); e_zero = (r == 0); e_neg = r[31];
    end
    @(posedge clk); #1;
    chk({req, " result"}, result_q, r);
    chk({req, " flags"}, {29'd0, flag_ovf, flag_zero, flag_neg}, {29'd0, e_ovf, e_zero, e_neg});
  endtask

  task automatic sweep_jumps(input string tag);
    for (int c = 0; c < 16; c++) begin
      br_code = 4'(c);
      #1;
      chk({(c > 6) ? "R9" : "R8", " jump ", tag}, {31'd0, jump_taken}, {31'd0, ref_jump(c, e_ovf, e_zero, e_neg)});
    end
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R7 result", result_q, 32'd0);
    chk("R7 flags", {29'd0, flag_ovf, flag_zero, flag_neg}, 32'd2);
    e_ovf = 0; e_zero = 1; e_neg = 0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_add;
    do_op("R1", 2'd0, 32'd5, 32'd7, 1'b1);
    do_op("R1 R4 pos overflow", 2'd0, 32'd1, 32'h7fffffff, 1'b1);
    do_op("R1 R4 neg overflow", 2'd0, 32'h80000000, 32'h80000000, 1'b1);
    do_op("R1 R5 zero", 2'd0, 32'hffffffff, 32'd1, 1'b1);
  endtask

  task automatic t_sub;
    do_op("R2", 2'd1, 32'd3, 32'd10, 1'b1);
    do_op("R2 R5 negative", 2'd1, 32'd10, 32'd3, 1'b1);
    do_op("R2 R4 overflow", 2'd1, 32'd1, 32'h80000000, 1'b1);
    do_op("R2 R4 no overflow same sign", 2'd1, 32'h80000000, 32'h80000000, 1'b1);
    do_op("R2 R4 overflow neg a", 2'd1, 32'h80000000, 32'd0, 1'b1);
  endtask

  task automatic t_logic;
    do_op("R4 set ovf", 2'd0, 32'd1, 32'h7fffffff, 1'b1);
    do_op("R3 R4 and", 2'd2, 32'hf0f0f0f0, 32'hff00ff00, 1'b1);
    do_op("R4 set ovf again", 2'd0, 32'd1, 32'h7fffffff, 1'b1);
    do_op("R3 R4 xor", 2'd3, 32'h12345678, 32'h12345678, 1'b1);
  endtask

  task automatic t_hold;
    do_op("R6 setup", 2'd1, 32'd1, 32'h80000000, 1'b1);
    do_op("R6 hold", 2'd0, 32'd0, 32'd0, 1'b0);
    do_op("R6 hold xor", 2'd3, 32'd1, 32'd0, 1'b0);
  endtask

  task automatic t_jumps;
    do_op("R8 eq state", 2'd1, 32'd9, 32'd9, 1'b1);      sweep_jumps("zero");
    do_op("R8 lt state", 2'd1, 32'd9, 32'd2, 1'b1);      sweep_jumps("less");
    do_op("R8 gt state", 2'd1, 32'd2, 32'd9, 1'b1);      sweep_jumps("greater");
    do_op("R8 ovf lt", 2'd1, 32'd1, 32'h80000000, 1'b1); sweep_jumps("ovf");
    do_op("R8 ovf neg", 2'd0, 32'h80000000, 32'h80000000, 1'b1); sweep_jumps("ovf zero");
  endtask

  task automatic t_stored;
    do_op("R10 setup", 2'd0, 32'd0, 32'd0, 1'b1);
    @(negedge clk);
    br_code = 4'd3; op_code = 2'd0; opnd_a = 32'd4; opnd_b = 32'd4; flag_we = 1'b1;
    #1;
    chk("R10 before edge", {31'd0, jump_taken}, 32'd1);
    @(posedge clk); #1;
    chk("R10 after edge", {31'd0, jump_taken}, 32'd0);
    e_ovf = 0; e_zero = 0; e_neg = 0;
  endtask

  initial begin
    rst = 1'b1; op_code = 0; opnd_a = 0; opnd_b = 0; flag_we = 0; br_code = 0;
    repeat (2) @(posedge clk);
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_hold();
    t_jumps();
    t_stored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule